// File: doc/BRIEF.md
# Bus command issue sequencer

This block plays a short stored program of cycle-level operations onto the request side of a packet bus port. Each program line holds an opcode and a 32-bit argument. The opcodes are initialise, start/stop pulse, read-block request, wait, jump and halt. A cycle counter times the fixed strobe pattern of each operation. A line pointer selects the operation that runs. The block registers the `send`, `load` and `ttop` strobes and the 5-bit request-arbitration code.

The block also keeps five 68-bit bus words. The initialise operation fills them with the values 0 to 4. A read request writes word 0 with a header cycle assembled in hardware from the command code, the device number and the address. Arbitration, reply handling, parity and the data cycles that follow a header are outside this block. The program image is a parameter, so one instance replays one fixed command script after each reset.

Top module: `bcs_sequencer`

## Requirements
- R1: On the clock edge that samples `rst` high, all strobes, the request code and all five bus words go to zero, and the sequencer restarts at line 0 with a count of 0.
- R2: Initialise (opcode 1) lasts 5 cycles. `load` is high for the first 4 cycles and low in the 5th. `send`, `ttop` and the request code are low throughout.
- R3: During initialise, bus word k (bits k*68 to k*68+67 of `bus_words`) is loaded with the value k, for k = 0 to 4.
- R4: Start/stop (opcode 2) lasts 12 cycles. `load` is high for cycles 1 to 11. `ttop` is low for cycles 1 to 5 and high for cycles 6 to 11. Both are low in cycle 12.
- R5: Read request (opcode 3) lasts 5 cycles. `send` and `load` are both high in cycles 1 and 2. Only `load` is high in cycles 3 and 4. Both are low in cycle 5.
- R6: A read request drives the request code 16 (mode 10000, two-cycle length, low priority). The code holds that value until another operation changes it.
- R7: The header written to word 0 has bit 0 set. Bits 1, 2, 3, 9 and 10 are zero.
- R8: Header bits 4 to 8 carry the command (0 for read block), bits 11 to 20 carry the device number (0), and bits 21 to 35 are zero. Bits 36 to 67 carry the argument address with its two 16-bit halves exchanged, so address bit 0 lands at header bit 52 and address bit 16 at header bit 36.
- R9: Wait (opcode 4) with argument n lasts n+1 cycles and leaves every output unchanged.
- R10: Jump (opcode 5) lasts one cycle, leaves the outputs unchanged and continues at the line given by the low bits of its argument. Skipped lines have no effect.
- R11: Halt (opcode 0), and any unused opcode, drives the strobes and request code low, keeps the bus words and stays on its line until reset.
- R12: A program entry is {opcode[2:0], argument[31:0]}. Line i occupies bits i*35 to i*35+34 of the image parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send | output | 1 | Send strobe |
| load | output | 1 | Load strobe |
| ttop | output | 1 | Start/stop strobe |
| rq_code | output | 5 | Request-arbitration code |
| bus_words | output | 340 | Five 68-bit bus words; word k at bits k*68 +: 68 |

## Verification
Each opcode has a fixed length, so a corrupted counter or line pointer shows up as a shift in the strobe trace. That shift appears on the first cycle where an operation ends early or late, and it moves every later edge. A wrong header bit shows up in word 0 in the first cycle of the read and persists through halt. The bench therefore compares the complete strobe and code trace cycle by cycle, and compares the bus words at the end of initialise, at each read and after halt. A jump to the wrong line shows up either as an extra read or as a changed final header.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int OP_W    = 3;
  localparam int ARG_W   = 32;
  localparam int ENTRY_W = OP_W + ARG_W;
  localparam int RQ_W    = 5;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 3'd0,
    OP_INIT  = 3'd1,
    OP_PULSE = 3'd2,
    OP_READ  = 3'd3,
    OP_WAIT  = 3'd4,
    OP_JUMP  = 3'd5
  } op_e;

  // strobe timing, in counter values
  localparam int INIT_LAST      = 4;
  localparam int PULSE_HI_FIRST = 5;
  localparam int PULSE_HI_LAST  = 10;
  localparam int READ_SEND_LAST = 1;
  localparam int READ_LOAD_LAST = 3;

  localparam logic [RQ_W-1:0] RQ_READ        = 5'd16;
  localparam logic [4:0]      CMD_READ_BLOCK = 5'd0;

  function automatic logic [ENTRY_W-1:0] mk_entry(logic [OP_W-1:0] op, logic [ARG_W-1:0] arg);
    return {op, arg};
  endfunction

  // line 0 is the least significant entry
  localparam logic [8*ENTRY_W-1:0] DEFAULT_PROG = {
    mk_entry(OP_HALT,  32'd0),
    mk_entry(OP_READ,  32'hFFFF_FFFF),
    mk_entry(OP_JUMP,  32'd7),
    mk_entry(OP_READ,  32'hCAFE_0001),
    mk_entry(OP_WAIT,  32'd2),
    mk_entry(OP_READ,  32'h1234_5678),
    mk_entry(OP_PULSE, 32'd0),
    mk_entry(OP_INIT,  32'd0)
  };
endpackage

// File: rtl/bcs_prog_rom.sv
module bcs_prog_rom #(
  parameter int PC_W    = 3,
  parameter int ENTRY_W = 35,
  parameter logic [(2**PC_W)*ENTRY_W-1:0] IMAGE = '0
) (
  input  logic [PC_W-1:0]    addr,
  output logic [ENTRY_W-1:0] data
);
  localparam int DEPTH = 2**PC_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    assign mem[i] = IMAGE[i*ENTRY_W +: ENTRY_W];
  end

  assign data = mem[addr];
endmodule

// File: rtl/bcs_header_build.sv
module bcs_header_build #(
  parameter int CMD_W  = 5,
  parameter int DEV_W  = 10,
  parameter int PAD_W  = 15,
  parameter int ADDR_W = 32
) (
  input  logic [CMD_W-1:0]                    cmd,
  input  logic [DEV_W-1:0]                    dev,
  input  logic [ADDR_W-1:0]                   addr,
  output logic [4+CMD_W+2+DEV_W+PAD_W+ADDR_W-1:0] hdr
);
  localparam int CMD_LSB  = 4;
  localparam int DEV_LSB  = CMD_LSB + CMD_W + 2;
  localparam int ADDR_LSB = DEV_LSB + DEV_W + PAD_W;
  localparam int HALF     = ADDR_W / 2;

  always_comb begin
    hdr                       = '0;
    hdr[0]                    = 1'b1;
    hdr[CMD_LSB +: CMD_W]     = cmd;
    hdr[DEV_LSB +: DEV_W]     = dev;
    hdr[ADDR_LSB +: ADDR_W]   = {addr[HALF-1:0], addr[ADDR_W-1:HALF]};
  end
endmodule

// File: rtl/bcs_step.sv
module bcs_step
  import bcs_pkg::*;
#(
  parameter int PC_W  = 3,
  parameter int CNT_W = 16
) (
  input  logic [OP_W-1:0]  op,
  input  logic [CNT_W-1:0] wait_n,
  input  logic [PC_W-1:0]  jump_to,
  input  logic [PC_W-1:0]  pc,
  input  logic [CNT_W-1:0] cnt,
  input  logic             send_i,
  input  logic             load_i,
  input  logic             ttop_i,
  input  logic [RQ_W-1:0]  rq_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             send_o,
  output logic             load_o,
  output logic             ttop_o,
  output logic [RQ_W-1:0]  rq_o,
  output logic             hdr_we,
  output logic             init_we
);
  logic [CNT_W-1:0] cnt_inc;
  logic [PC_W-1:0]  pc_inc;

  assign cnt_inc = cnt + CNT_W'(1);
  assign pc_inc  = pc + PC_W'(1);

  always_comb begin
    pc_o    = pc;
    cnt_o   = cnt;
    send_o  = send_i;
    load_o  = load_i;
    ttop_o  = ttop_i;
    rq_o    = rq_i;
    hdr_we  = 1'b0;
    init_we = 1'b0;
    case (op_e'(op))
      OP_INIT: begin
        rq_o    = '0;
        send_o  = 1'b0;
        ttop_o  = 1'b0;
        init_we = 1'b1;
        if (cnt < CNT_W'(INIT_LAST)) begin
          cnt_o  = cnt_inc;
          load_o = 1'b1;
        end else begin
          cnt_o  = '0;
          load_o = 1'b0;
          pc_o   = pc_inc;
        end
      end
      OP_PULSE: begin
        if (cnt < CNT_W'(PULSE_HI_FIRST)) begin
          ttop_o = 1'b0;
          load_o = 1'b1;
          cnt_o  = cnt_inc;
        end else if (cnt <= CNT_W'(PULSE_HI_LAST)) begin
          ttop_o = 1'b1;
          load_o = 1'b1;
          cnt_o  = cnt_inc;
        end else begin
          ttop_o = 1'b0;
          load_o = 1'b0;
          cnt_o  = '0;
          pc_o   = pc_inc;
        end
      end
      OP_READ: begin
        rq_o   = RQ_READ;
        hdr_we = 1'b1;
        if (cnt <= CNT_W'(READ_SEND_LAST)) begin
          send_o = 1'b1;
          load_o = 1'b1;
          cnt_o  = cnt_inc;
        end else if (cnt <= CNT_W'(READ_LOAD_LAST)) begin
          send_o = 1'b0;
          cnt_o  = cnt_inc;
        end else begin
          load_o = 1'b0;
          cnt_o  = '0;
          pc_o   = pc_inc;
        end
      end
      OP_WAIT: begin
        if (cnt < wait_n) begin
          cnt_o = cnt_inc;
        end else begin
          cnt_o = '0;
          pc_o  = pc_inc;
        end
      end
      OP_JUMP: begin
        pc_o  = jump_to;
        cnt_o = '0;
      end
      default: begin
        send_o = 1'b0;
        load_o = 1'b0;
        ttop_o = 1'b0;
        rq_o   = '0;
      end
    endcase
  end
endmodule

// File: rtl/bcs_sequencer.sv
module bcs_sequencer
  import bcs_pkg::*;
#(
  parameter int PC_W      = 3,
  parameter int CNT_W     = 16,
  parameter int CMD_W     = 5,
  parameter int DEV_W     = 10,
  parameter int PAD_W     = 15,
  parameter int ADDR_W    = 32,
  parameter int NUM_WORDS = 5,
  parameter logic [(2**PC_W)*ENTRY_W-1:0] PROGRAM = DEFAULT_PROG
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 send,
  output logic                 load,
  output logic                 ttop,
  output logic [RQ_W-1:0]      rq_code,
  output logic [NUM_WORDS*(4+CMD_W+2+DEV_W+PAD_W+ADDR_W)-1:0] bus_words
);
  localparam int WORD_W = 4 + CMD_W + 2 + DEV_W + PAD_W + ADDR_W;

  logic [PC_W-1:0]    pc_q, pc_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               send_d, load_d, ttop_d;
  logic [RQ_W-1:0]    rq_d;
  logic               hdr_we, init_we;
  logic [ENTRY_W-1:0] entry;
  logic [OP_W-1:0]    op;
  logic [ARG_W-1:0]   arg;
  logic [WORD_W-1:0]  hdr;

  bcs_prog_rom #(.PC_W(PC_W), .ENTRY_W(ENTRY_W), .IMAGE(PROGRAM)) u_rom (
    .addr (pc_q),
    .data (entry)
  );

  assign op  = entry[ENTRY_W-1 -: OP_W];
  assign arg = entry[ARG_W-1:0];

  bcs_header_build #(.CMD_W(CMD_W), .DEV_W(DEV_W), .PAD_W(PAD_W), .ADDR_W(ADDR_W)) u_hdr (
    .cmd  (CMD_W'(CMD_READ_BLOCK)),
    .dev  ('0),
    .addr (arg[ADDR_W-1:0]),
    .hdr  (hdr)
  );

  bcs_step #(.PC_W(PC_W), .CNT_W(CNT_W)) u_step (
    .op      (op),
    .wait_n  (arg[CNT_W-1:0]),
    .jump_to (arg[PC_W-1:0]),
    .pc      (pc_q),
    .cnt     (cnt_q),
    .send_i  (send),
    .load_i  (load),
    .ttop_i  (ttop),
    .rq_i    (rq_code),
    .pc_o    (pc_d),
    .cnt_o   (cnt_d),
    .send_o  (send_d),
    .load_o  (load_d),
    .ttop_o  (ttop_d),
    .rq_o    (rq_d),
    .hdr_we  (hdr_we),
    .init_we (init_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      cnt_q   <= '0;
      send    <= 1'b0;
      load    <= 1'b0;
      ttop    <= 1'b0;
      rq_code <= '0;
    end else begin
      pc_q    <= pc_d;
      cnt_q   <= cnt_d;
      send    <= send_d;
      load    <= load_d;
      ttop    <= ttop_d;
      rq_code <= rq_d;
    end
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    if (k == 0) begin : g_hdr_slot
      always_ff @(posedge clk) begin
        if (rst)          word_q <= '0;
        else if (init_we) word_q <= WORD_W'(k);
        else if (hdr_we)  word_q <= hdr;
      end
    end else begin : g_plain_slot
      always_ff @(posedge clk) begin
        if (rst)          word_q <= '0;
        else if (init_we) word_q <= WORD_W'(k);
      end
    end
    assign bus_words[k*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/bcs_sequencer_chk.sv
module bcs_sequencer_chk #(
  parameter int RQ_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            send,
  input logic            load,
  input logic            ttop,
  input logic [RQ_W-1:0] rq_code,
  input logic [10:0]     hdr_low,
  input logic            words_zero
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!send && !load && !ttop && rq_code == '0 && words_zero));

  assert_send_needs_load_R5: assert property (@(posedge clk) disable iff (rst)
    send |-> load);

  assert_send_two_cycles_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(send) |=> send ##1 !send);

  assert_ttop_needs_load_R4: assert property (@(posedge clk) disable iff (rst)
    ttop |-> load);

  assert_ttop_ends_with_load_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ttop) |-> !load);

  assert_send_code_R6: assert property (@(posedge clk) disable iff (rst)
    send |-> rq_code == RQ_W'(16));

  assert_header_fixed_bits_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(send) |-> (hdr_low[0] && hdr_low[10:1] == '0));
endmodule

bind bcs_sequencer bcs_sequencer_chk #(.RQ_W(bcs_pkg::RQ_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .send       (send),
  .load       (load),
  .ttop       (ttop),
  .rq_code    (rq_code),
  .hdr_low    (bus_words[10:0]),
  .words_zero (bus_words == '0)
);

// File: tb/sim_bcs_sequencer.sv
`timescale 1ns/1ps
module sim_bcs_sequencer;
  localparam int W  = 68;
  localparam int NW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          send, load, ttop;
  logic [4:0]    rq_code;
  logic [NW*W-1:0] bus_words;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bcs_sequencer u0 (
    .clk(clk), .rst(rst), .send(send), .load(load), .ttop(ttop),
    .rq_code(rq_code), .bus_words(bus_words)
  );

  function automatic logic [W-1:0] hdr_of(input logic [31:0] a);
    return {a[15:0], a[31:16], 15'd0, 10'd0, 2'b00, 5'd0, 3'b000, 1'b1};
  endfunction

  // {req[3:0], run length[5:0], send, load, ttop, rq[4:0]}
  localparam int NV = 14;
  localparam logic [17:0] TRACE [NV] = '{
    {4'd2,  6'd4, 3'b010, 5'd0},
    {4'd2,  6'd1, 3'b000, 5'd0},
    {4'd4,  6'd5, 3'b010, 5'd0},
    {4'd4,  6'd6, 3'b011, 5'd0},
    {4'd4,  6'd1, 3'b000, 5'd0},
    {4'd5,  6'd2, 3'b110, 5'd16},
    {4'd5,  6'd2, 3'b010, 5'd16},
    {4'd5,  6'd1, 3'b000, 5'd16},
    {4'd9,  6'd3, 3'b000, 5'd16},
    {4'd5,  6'd2, 3'b110, 5'd16},
    {4'd5,  6'd2, 3'b010, 5'd16},
    {4'd6,  6'd1, 3'b000, 5'd16},
    {4'd10, 6'd1, 3'b000, 5'd16},
    {4'd11, 6'd4, 3'b000, 5'd0}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word(input int k);
    return bus_words[k*W +: W];
  endfunction

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 strobes", W'({send, load, ttop, rq_code}), '0);
    chk("R1 words", W'(bus_words == '0), W'(1));
    rst = 1'b0;

    // table walk: R2 R4 R5 R6 R9 R10 R11 R12
    foreach (TRACE[v]) begin
      for (int n = 0; n < int'(TRACE[v][13:8]); n++) begin
        @(posedge clk);
        @(negedge clk);
        cyc++;
        chk($sformatf("R%0d cycle %0d", TRACE[v][17:14], cyc),
            W'({send, load, ttop, rq_code}), W'(TRACE[v][7:0]));
        if (cyc == 5) begin
          for (int k = 0; k < NW; k++)
            chk($sformatf("R3 word %0d", k), word(k), W'(k));
        end
        if (cyc == 18) chk("R8 R7 header A", word(0), hdr_of(32'h1234_5678));
        if (cyc == 26) chk("R8 header B", word(0), hdr_of(32'hCAFE_0001));
        if (cyc == 35) begin
          chk("R10 skipped line leaves header", word(0), hdr_of(32'hCAFE_0001));
          chk("R11 words held", word(4), W'(4));
        end
      end
    end

    // R11: halt persists
    for (int n = 0; n < 20; n++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R11 halt holds strobes low", W'({send, load, ttop, rq_code}), '0);
    end

    // R1: reset from halt clears words
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset from halt strobes", W'({send, load, ttop, rq_code}), '0);
    chk("R1 reset from halt words", W'(bus_words == '0), W'(1));
    rst = 1'b0;

    // R1 R2: restart at line 0, then reset in the middle of start/stop
    @(posedge clk);
    @(negedge clk);
    chk("R2 restart first cycle", W'({send, load, ttop, rq_code}), W'(8'b010_00000));
    repeat (11) @(posedge clk);
    @(negedge clk);
    chk("R4 ttop high after restart", W'({send, load, ttop}), W'(3'b011));
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset mid pulse", W'({send, load, ttop, rq_code}), '0);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R2 init end after mid reset", W'({send, load, ttop, rq_code}), '0);
    chk("R3 word 2 after mid reset", word(2), W'(2));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule